// File: doc/BRIEF.md
# Asynchronous Pulse Capture Synchronizer

This block brings one asynchronous input into a clock domain. Only a single capture flip-flop ever sees that input. The capture flip-flop takes its clock from the input itself. A rising edge sets it at once, so an event is held even if the input drops again before the next clock edge. A chain of clocked guard stages follows the capture flip-flop. These stages give any metastable value time to resolve before it reaches the output. The last stage drives a clean synchronous level, and later logic may fan it out freely.

The capture flip-flop is cleared only after the domain has seen the event. The output must have been high for a cycle and the input must be low again. Because of this, a pulse narrower than a clock period always gives a complete output event. A long pulse keeps the output high for as long as the input stays high. Several narrow pulses that arrive within one clock period collapse into a single event. The number of guard stages is a parameter.

Top module: `pulseCaptureSync`

## Requirements
- R1: While `rst` is sampled high at a clock edge, all guard stages are cleared and the capture flip-flop is cleared. After reset the output stays 0 for as long as no input edge arrives, and this includes an event that was captured just before reset.
- R2: An input pulse narrower than one clock period (here 1 to 3 ns against a 20 ns period) produces an asserted output.
- R3: With the default of 2 stages, the output first reads high after the second rising clock edge that follows the input's rising edge. An edge that falls after a clock edge is counted from the next edge.
- R4: For a pulse that outlasts the clear window, the output stays high until the input falls. It then drops after the SYNC_STAGES-th clock edge that follows the input's falling edge.
- R5: The capture flip-flop clears only once the output has been seen high for a cycle and the input is low. A narrow pulse therefore holds the output high for exactly SYNC_STAGES+1 cycles.
- R6: Several narrow pulses that fall between the same two clock edges yield one output event of the same length as a single pulse.
- R7: The parameter SYNC_STAGES (at least 2, default 2) sets the number of guard stages. With 3 stages the output rises one edge later and a narrow pulse gives a 4-cycle output event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination domain clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| asyncIn | input | 1 | Asynchronous event input, rising edge captured |
| syncOut | output | 1 | Synchronized level output |

## Verification
The bench places pulses just before a clock edge and just after one, to check that the latency count moves by exactly one edge. A design that sampled the level instead of capturing the edge would miss the 1 ns and 3 ns pulses completely. A burst of three pulses inside one period must give one event of normal length; a clear path that re-armed too early would stretch or split it. The bench also compares long pulses of several widths against the input's falling edge, and sends a pulse that is followed at once by reset. A capture flip-flop that survived reset would then raise the output afterwards.

// File: rtl/pulseSyncPkg.sv
package pulseSyncPkg;

  // Strobes from the control side to the capture datapath
  typedef struct packed {
    logic syncReset;     // clear guard stages this edge
    logic holdCapClear;  // force capture element clear (reset follow-up)
    logic outSeen;       // output was high last cycle: clear when input low
  } syncStrobeT;

endpackage

// File: rtl/syncControl.sv
module syncControl
  import pulseSyncPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       syncLevel,
  output syncStrobeT strobe
);

  logic rstHold;
  logic outSeenQ;

  // Registered copy of reset drives the capture clear as a clean level
  always_ff @(posedge clk) begin
    rstHold <= rst;
  end

  // Remember that the domain has observed the event
  always_ff @(posedge clk) begin
    if (rst) outSeenQ <= 1'b0;
    else     outSeenQ <= syncLevel;
  end

  always_comb begin
    strobe.syncReset    = rst;
    strobe.holdCapClear = rstHold;
    strobe.outSeen      = outSeenQ;
  end

endmodule

// File: rtl/captureDatapath.sv
module captureDatapath
  import pulseSyncPkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       asyncIn,
  input  syncStrobeT strobe,
  output logic       capFlag,
  output logic       syncLevel
);

  localparam int LAST = STAGES - 1;

  logic capQ;
  logic capClear;
  logic [LAST:0] stageQ;

  // Clear once the event is seen and the input has gone low again
  assign capClear = strobe.holdCapClear | (strobe.outSeen & ~asyncIn);

  // The only flip-flop that the asynchronous input touches
  always_ff @(posedge asyncIn or posedge capClear) begin
    if (capClear) capQ <= 1'b0;
    else          capQ <= 1'b1;
  end

  // Metastability guard chain
  generate
    for (genvar g = 0; g < STAGES; g++) begin : gStage
      always_ff @(posedge clk) begin
        if (strobe.syncReset) stageQ[g] <= 1'b0;
        else if (g == 0)      stageQ[g] <= capQ;
        else                  stageQ[g] <= stageQ[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign capFlag   = capQ;
  assign syncLevel = stageQ[LAST];

endmodule

// File: rtl/pulseCaptureSync.sv
module pulseCaptureSync
  import pulseSyncPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);

  syncStrobeT strobe;
  logic capFlag;
  logic syncLevel;
  logic clearArm;

  syncControl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .syncLevel(syncLevel),
    .strobe   (strobe)
  );

  captureDatapath #(.STAGES(SYNC_STAGES)) uPath (
    .clk      (clk),
    .asyncIn  (asyncIn),
    .strobe   (strobe),
    .capFlag  (capFlag),
    .syncLevel(syncLevel)
  );

  assign clearArm = strobe.holdCapClear | strobe.outSeen;
  assign syncOut  = syncLevel;

endmodule

// File: rtl/pulseCaptureSyncChecker.sv
module pulseCaptureSyncChecker #(
  parameter int STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic syncOut,
  input logic capFlag,
  input logic clearArm
);

  // R1: a reset edge leaves the output low
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> !syncOut);

  // R2: output can only rise when an event was captured
  p_rise_needs_capture_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(syncOut) |-> $past(capFlag));

  // R3: default depth gives output two edges after capture is seen
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(capFlag) && (STAGES == 2)) |-> ##2 syncOut);

  // R5: capture clears only while the clear path is armed
  p_clear_when_armed_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(capFlag) |-> clearArm);

endmodule

bind pulseCaptureSync pulseCaptureSyncChecker #(.STAGES(SYNC_STAGES)) uChk (
  .clk     (clk),
  .rst     (rst),
  .syncOut (syncOut),
  .capFlag (capFlag),
  .clearArm(clearArm)
);

// File: tb/sim_pulseCaptureSync.sv
`timescale 1ns/1ps
module sim_pulseCaptureSync;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic asyncIn = 1'b0;
  logic out2, out3;
  int checkCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  pulseCaptureSync #(.SYNC_STAGES(2)) u0 (.clk(clk), .rst(rst), .asyncIn(asyncIn), .syncOut(out2));
  pulseCaptureSync #(.SYNC_STAGES(3)) u1 (.clk(clk), .rst(rst), .asyncIn(asyncIn), .syncOut(out3));

  // offset ns after negedge, width ns, first-high index and count for 2 and 3 stages
  localparam int NVEC = 8;
  localparam int VEC[NVEC][6] = '{
    '{5,   3, 2,  3, 3,  4},   // R2 narrow pulse
    '{2,   3, 2,  3, 3,  4},
    '{8,   1, 2,  3, 3,  4},
    '{12,  3, 3,  3, 4,  4},   // R3 edge just after clock edge
    '{5,  30, 2,  3, 3,  4},
    '{5,  60, 2,  3, 3,  4},
    '{5, 100, 2,  5, 3,  5},   // R4 long pulse
    '{5, 200, 2, 10, 3, 10}
  };

  task automatic check(input string req, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int f2, output int c2, output int f3, output int c3);
    f2 = 0; c2 = 0; f3 = 0; c3 = 0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (out2) begin c2++; if (f2 == 0) f2 = k; end
      if (out3) begin c3++; if (f3 == 0) f3 = k; end
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int f2, c2, f3, c3, stuck;
    repeat (3) @(negedge clk);
    check("R1 reset out 2-stage", int'(out2), 0);
    check("R1 reset out 3-stage", int'(out3), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // idle: no edges, output stays low
    stuck = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (out2 || out3) stuck++; end
    check("R1 idle stays low", stuck, 0);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      fork
        begin #(VEC[v][0]); asyncIn = 1'b1; #(VEC[v][1]); asyncIn = 1'b0; end
        measure(f2, c2, f3, c3);
      join
      check($sformatf("R3 first high v%0d", v), f2, VEC[v][2]);
      check($sformatf("R5 R4 high count v%0d", v), c2, VEC[v][3]);
      check($sformatf("R7 first high 3-stage v%0d", v), f3, VEC[v][4]);
      check($sformatf("R7 high count 3-stage v%0d", v), c3, VEC[v][5]);
    end

    // R6: three narrow pulses in one period
    @(negedge clk);
    fork
      begin
        #1 asyncIn = 1'b1; #2 asyncIn = 1'b0;
        #1 asyncIn = 1'b1; #2 asyncIn = 1'b0;
        #1 asyncIn = 1'b1; #2 asyncIn = 1'b0;
      end
      measure(f2, c2, f3, c3);
    join
    check("R6 burst first high", f2, 2);
    check("R6 burst one event", c2, 3);
    check("R6 burst one event 3-stage", c3, 4);

    // R1: event captured then reset before it reaches output
    @(negedge clk);
    fork
      begin #5 asyncIn = 1'b1; #3 asyncIn = 1'b0; end
      begin #6 rst = 1'b1; end
    join
    repeat (2) @(negedge clk);
    rst = 1'b0;
    stuck = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); if (out2 || out3) stuck++; end
    check("R1 reset drops captured event", stuck, 0);

    // after that, a fresh narrow pulse still works
    @(negedge clk);
    fork
      begin #5 asyncIn = 1'b1; #2 asyncIn = 1'b0; end
      measure(f2, c2, f3, c3);
    join
    check("R2 pulse after reset", c2, 3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule